// File: doc/BRIEF.md
# Two-Level Carry Lookahead Adder

A 16-bit binary adder split into four 4-bit slices. Each slice forms per-bit generate and propagate terms. It derives all of its internal carries as flat sum-of-products expressions of those terms and the slice carry-in, so no internal carry waits on another. Each slice hands a group generate and a group propagate to a second-level lookahead unit. That unit uses the same equations to produce the carry into every upper slice and the final carry-out straight from the group terms and the adder carry-in. Carries never ripple from slice to slice.

The result, the carry-out and the overall group propagate and generate are captured in an output register, one clock after the operands. The group pair lets a wider adder treat this block as one lookahead digit. A synchronous active-high reset clears the output register. Slice width and slice count are parameters; the defaults give 16 bits.

Top module: `cla_adder`

## Requirements
- R1: One clock edge after operands `a_in`, `b_in` and `c_in` are sampled with `rst` low, `sum_q` equals the low 16 bits of `a_in + b_in + c_in`.
- R2: In that same cycle, `cout_q` equals bit 16 of `a_in + b_in + c_in`, the carry out of the top slice.
- R3: `grp_p_q` is 1 exactly when every bit of `a_in ^ b_in` is 1, so that a carry-in would pass through the whole adder.
- R4: `grp_g_q` is 1 exactly when `a_in + b_in`, with a carry-in of 0, carries out of bit 15.
- R5: `cout_q` always equals `grp_g_q | (grp_p_q & c_in)` for the sampled carry-in.
- R6: When `rst` is high at a clock edge, `sum_q`, `cout_q`, `grp_p_q` and `grp_g_q` are all 0 after that edge, whatever the inputs.
- R7: The worst case for a single slice, 4'b1111 + 4'b0001, gives the right result with no ripple: 0x000F + 0x0001 gives sum 0x0010. All ones plus one (0xFFFF + 0x0001) gives sum 0 and carry-out 1.
- R8: A carry that crosses slice boundaries is delivered by the second-level unit. 0x0FFF + 0x0001 gives 0x1000, 0x00FF + 0x0001 gives 0x0100, and 0xFFFF + 0x0000 with carry-in 1 gives sum 0, carry-out 1, group propagate 1 and group generate 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a_in | input | 16 | First operand |
| b_in | input | 16 | Second operand |
| c_in | input | 1 | Carry into bit 0 |
| sum_q | output | 16 | Registered sum |
| cout_q | output | 1 | Registered carry out of bit 15 |
| grp_p_q | output | 1 | Registered overall group propagate |
| grp_g_q | output | 1 | Registered overall group generate |

## Verification
On every clock after reset, the bound checker compares the registered sum and carry with a plain arithmetic sum of the previous operands. It also checks the overall propagate and generate against their bitwise definitions, ties the carry-out to the group pair, and checks that reset clears all outputs. Those checks do not by themselves steer the operands onto the hard patterns: the single-slice worst case, the carries that cross one, two or three slice boundaries, and the full-width propagate chain fed only by the carry-in. The bench's vector table and its directed reset cases drive those patterns on purpose.

// File: rtl/cla_pkg.sv
package cla_pkg;
  // Widest generate/propagate vector the lookahead helpers accept.
  localparam int LA_MAX = 16;

  // Carry into position k, written as a flat OR of AND terms over g, p and c0.
  function automatic logic la_carry(input logic [LA_MAX-1:0] g,
                                    input logic [LA_MAX-1:0] p,
                                    input logic              c0,
                                    input int                k);
    logic acc;
    logic term;
    acc = 1'b0;
    for (int j = 0; j < k; j++) begin
      term = g[j];
      for (int i = j + 1; i < k; i++) term &= p[i];
      acc |= term;
    end
    term = c0;
    for (int i = 0; i < k; i++) term &= p[i];
    acc |= term;
    return acc;
  endfunction

  // Group propagate over the lowest k positions.
  function automatic logic la_prop(input logic [LA_MAX-1:0] p, input int k);
    logic acc;
    acc = 1'b1;
    for (int i = 0; i < k; i++) acc &= p[i];
    return acc;
  endfunction
endpackage

// File: rtl/cla_slice.sv
module cla_slice
  import cla_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         grp_p,
  output logic         grp_g
);
  logic [W-1:0]      bit_g;
  logic [W-1:0]      bit_p;
  logic [W-1:0]      carry;
  logic [LA_MAX-1:0] gx;
  logic [LA_MAX-1:0] px;

  assign bit_g = a & b;
  assign bit_p = a ^ b;
  assign gx    = LA_MAX'(bit_g);
  assign px    = LA_MAX'(bit_p);

  // Every internal carry comes from g, p and cin only, never from another carry.
  for (genvar k = 0; k < W; k++) begin : g_carry
    if (k == 0) begin : g_first
      assign carry[k] = cin;
    end else begin : g_rest
      assign carry[k] = la_carry(gx, px, cin, k);
    end
  end

  assign sum   = bit_p ^ carry;
  assign grp_g = la_carry(gx, px, 1'b0, W);
  assign grp_p = la_prop(px, W);
endmodule

// File: rtl/cla_lcu.sv
module cla_lcu
  import cla_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0] gp,
  input  logic [N-1:0] gg,
  input  logic         c0,
  output logic [N-1:0] carry_o,  // carry_o[k] feeds slice k+1; the top bit is the carry-out
  output logic         all_p,
  output logic         all_g
);
  logic [LA_MAX-1:0] gx;
  logic [LA_MAX-1:0] px;

  assign gx = LA_MAX'(gg);
  assign px = LA_MAX'(gp);

  for (genvar k = 1; k <= N; k++) begin : g_carry
    assign carry_o[k-1] = la_carry(gx, px, c0, k);
  end

  assign all_g = la_carry(gx, px, 1'b0, N);
  assign all_p = la_prop(px, N);
endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
  parameter int SLICE_W  = 4,
  parameter int N_SLICES = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [SLICE_W*N_SLICES-1:0]   a_in,
  input  logic [SLICE_W*N_SLICES-1:0]   b_in,
  input  logic                          c_in,
  output logic [SLICE_W*N_SLICES-1:0]   sum_q,
  output logic                          cout_q,
  output logic                          grp_p_q,
  output logic                          grp_g_q
);
  localparam int W = SLICE_W * N_SLICES;

  logic [W-1:0]        sum_d;
  logic [N_SLICES-1:0] slice_p;
  logic [N_SLICES-1:0] slice_g;
  logic [N_SLICES-1:0] lcu_c;
  logic                all_p;
  logic                all_g;

  for (genvar s = 0; s < N_SLICES; s++) begin : g_slice
    logic slice_cin;
    if (s == 0) begin : g_lo
      assign slice_cin = c_in;
    end else begin : g_hi
      assign slice_cin = lcu_c[s-1];
    end
    cla_slice #(.W(SLICE_W)) u_slice (
      .a     (a_in[s*SLICE_W +: SLICE_W]),
      .b     (b_in[s*SLICE_W +: SLICE_W]),
      .cin   (slice_cin),
      .sum   (sum_d[s*SLICE_W +: SLICE_W]),
      .grp_p (slice_p[s]),
      .grp_g (slice_g[s])
    );
  end

  cla_lcu #(.N(N_SLICES)) u_lcu (
    .gp      (slice_p),
    .gg      (slice_g),
    .c0      (c_in),
    .carry_o (lcu_c),
    .all_p   (all_p),
    .all_g   (all_g)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q   <= '0;
      cout_q  <= 1'b0;
      grp_p_q <= 1'b0;
      grp_g_q <= 1'b0;
    end else begin
      sum_q   <= sum_d;
      cout_q  <= lcu_c[N_SLICES-1];
      grp_p_q <= all_p;
      grp_g_q <= all_g;
    end
  end
endmodule

// File: rtl/cla_adder_chk.sv
module cla_adder_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic         c_in,
  input logic [W-1:0] sum_q,
  input logic         cout_q,
  input logic         grp_p_q,
  input logic         grp_g_q
);
  logic seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
  end

  // R1 R2
  sum_cout_chk: assert property (@(posedge clk) disable iff (rst)
    seen |-> ({cout_q, sum_q} ==
              ({1'b0, $past(a_in)} + {1'b0, $past(b_in)} + {{W{1'b0}}, $past(c_in)})));

  // R3
  grp_prop_chk: assert property (@(posedge clk) disable iff (rst)
    seen |-> (grp_p_q == (($past(a_in) ^ $past(b_in)) == {W{1'b1}})));

  // R4
  grp_gen_chk: assert property (@(posedge clk) disable iff (rst)
    seen |-> (grp_g_q == (({1'b0, $past(a_in)} + {1'b0, $past(b_in)}) >> W)));

  // R5
  cout_pg_chk: assert property (@(posedge clk) disable iff (rst)
    seen |-> (cout_q == (grp_g_q | (grp_p_q & $past(c_in)))));

  // R6
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (sum_q == '0 && !cout_q && !grp_p_q && !grp_g_q));
endmodule

bind cla_adder cla_adder_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .a_in    (a_in),
  .b_in    (b_in),
  .c_in    (c_in),
  .sum_q   (sum_q),
  .cout_q  (cout_q),
  .grp_p_q (grp_p_q),
  .grp_g_q (grp_g_q)
);

// File: tb/sim_cla_adder.sv
`timescale 1ns/1ps
module sim_cla_adder;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic         c_in = 1'b0;
  logic [W-1:0] sum_q;
  logic         cout_q;
  logic         grp_p_q;
  logic         grp_g_q;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cla_adder u0 (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .c_in(c_in),
    .sum_q(sum_q), .cout_q(cout_q), .grp_p_q(grp_p_q), .grp_g_q(grp_g_q)
  );

  // Stimulus table: {a, b, cin}
  localparam logic [2*W:0] VEC [14] = '{
    {16'h000F, 16'h0001, 1'b0},  // R7 slice worst case
    {16'hFFFF, 16'h0001, 1'b0},  // R7 all ones plus one
    {16'h0FFF, 16'h0001, 1'b0},  // R8 three boundaries
    {16'h00FF, 16'h0001, 1'b0},  // R8 two boundaries
    {16'h00F0, 16'h0010, 1'b0},  // R8 one boundary
    {16'hFFFF, 16'h0000, 1'b1},  // R8 carry-in through whole chain
    {16'hAAAA, 16'h5555, 1'b0},  // R3 propagate, no carry
    {16'hAAAA, 16'h5555, 1'b1},  // R3 R5 propagate with carry
    {16'h8000, 16'h8000, 1'b0},  // R4 generate at top
    {16'hFFFF, 16'hFFFF, 1'b1},
    {16'h0000, 16'h0000, 1'b0},
    {16'h1234, 16'h4321, 1'b1},
    {16'h7FFF, 16'h0000, 1'b1},
    {16'hF0F0, 16'h0F0F, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply_and_check(input logic [W-1:0] a, input logic [W-1:0] b, input logic ci);
    logic [W:0] full;
    logic [W:0] nocin;
    @(negedge clk);
    a_in = a; b_in = b; c_in = ci;
    full  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
    nocin = {1'b0, a} + {1'b0, b};
    @(negedge clk);
    check("R1 sum", 32'(sum_q), 32'(full[W-1:0]));
    check("R2 cout", 32'(cout_q), 32'(full[W]));
    check("R3 grp_p", 32'(grp_p_q), 32'((a ^ b) == {W{1'b1}}));
    check("R4 grp_g", 32'(grp_g_q), 32'(nocin[W]));
    check("R5 cout vs pg", 32'(cout_q), 32'(grp_g_q | (grp_p_q & ci)));
  endtask

  initial begin
    logic [31:0] lfsr;
    lfsr = 32'hACE1_2468;
    a_in = 16'hFFFF; b_in = 16'h0001; c_in = 1'b1;
    repeat (3) @(negedge clk);
    // R6 reset state with busy inputs
    check("R6 reset sum", 32'(sum_q), 32'h0);
    check("R6 reset cout", 32'(cout_q), 32'h0);
    check("R6 reset p/g", 32'({grp_p_q, grp_g_q}), 32'h0);
    rst = 1'b0;

    for (int i = 0; i < 14; i++)
      apply_and_check(VEC[i][2*W:W+1], VEC[i][W:1], VEC[i][0]);

    // R7 explicit worst-case values
    apply_and_check(16'hFFFF, 16'h0001, 1'b0);
    check("R7 all-ones sum", 32'(sum_q), 32'h0);
    check("R7 all-ones cout", 32'(cout_q), 32'h1);
    apply_and_check(16'h000F, 16'h0001, 1'b0);
    check("R7 slice sum", 32'(sum_q), 32'h0010);
    // R8 explicit cross-slice values
    apply_and_check(16'h0FFF, 16'h0001, 1'b0);
    check("R8 cross sum", 32'(sum_q), 32'h1000);
    apply_and_check(16'hFFFF, 16'h0000, 1'b1);
    check("R8 chain p/g/cout", 32'({grp_p_q, grp_g_q, cout_q}), 32'b101);

    // Random vectors
    for (int i = 0; i < 300; i++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      apply_and_check(lfsr[15:0], lfsr[31:16], lfsr[7]);
    end

    // R6 mid-run reset clears outputs
    @(negedge clk);
    a_in = 16'hFFFF; b_in = 16'hFFFF; c_in = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R6 midrun sum", 32'(sum_q), 32'h0);
    check("R6 midrun flags", 32'({cout_q, grp_p_q, grp_g_q}), 32'h0);
    rst = 1'b0;
    apply_and_check(16'h0001, 16'hFFFF, 1'b0);
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule